// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block orders the power-up and power-down steps of a display panel interface. Software writes a control word that carries a power request bit and a guard interval, counted in frame-start pulses from the display timing generator. On power-up, the panel signal group (pixel clock and syncs) is enabled first. Panel supply power follows only once the guard interval has elapsed. On power-down, panel supply power drops first. The signal group keeps running for the guard interval and then stops. One cycle later the block reports idle.

The busy output is high through every transitional phase. Software polls it, and changes no other display setting until it reads low. A guard value of zero is treated as one frame, so the ordering can never be skipped. If power is withdrawn while a power-up is still in progress, the block turns straight into the shutdown path. In that case panel power is never asserted.

Top module: `lcdpwr_seq`

## Requirements
- R1: After reset, sigEn, panelPwr and busy are all 0.
- R2: A write (wrEn=1) takes the power request from wrData bit 0 and the guard count from wrData[GUARD_LSB +: GUARD_W]. All other wrData bits have no effect on the outputs.
- R3: A write that requests power while the block is off raises sigEn and busy at the clock edge that samples the write. panelPwr rises, and busy falls, at the edge that samples the guard-th frameStart pulse. Before that edge panelPwr stays 0.
- R4: A write that clears the power request while the block is fully on drops panelPwr at the edge that samples the write. sigEn stays 1 until the edge that samples the guard-th frameStart pulse, and falls at that edge.
- R5: busy stays 1 in the cycle in which sigEn has just fallen. busy clears at the following edge.
- R6: A guard count of 0 behaves exactly like a guard count of 1.
- R7: frameStart pulses have no effect while the block is fully off or fully on.
- R8: Clearing the power request during a power-up wait aborts the wait without panelPwr ever rising. sigEn then falls after a fresh guard interval.
- R9: A power request written during shutdown does not stop the shutdown. After the idle cycle (all outputs 0), the power-up starts at the next edge.
- R10: Writing a power request while the block is already fully on leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | DATA_W | Control word: bit 0 is the power request; the guard count sits at GUARD_LSB |
| frameStart | input | 1 | One-cycle pulse at each frame start |
| sigEn | output | 1 | Panel signal group enable |
| panelPwr | output | 1 | Panel supply power enable |
| busy | output | 1 | High while a sequence is in progress |

## Verification
The bench builds the block with DATA_W=8, GUARD_W=3 and GUARD_LSB=1. This puts the largest guard count (7) within a short run, so the maximum-wait boundary is exercised. It also leaves bits 7:4 of the write word unused, which lets the bench set them to confirm they are ignored. Expected output triples are queued by the stimulus tasks and compared against the outputs at each following clock edge. This covers aborted power-ups, requests that arrive during shutdown, and zero guard counts.

// File: rtl/lcdpwr_pkg.sv
package lcdpwr_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_UP_WAIT,
    PS_ON,
    PS_DOWN_WAIT,
    PS_DRAIN
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;

endpackage

// File: rtl/lcdpwr_cfg_dp.sv
module lcdpwr_cfg_dp #(
  parameter int DATA_W    = 32,
  parameter int GUARD_W   = 8,
  parameter int GUARD_LSB = 16,
  parameter int GUARD_RST = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     frameStart,
  input  lcdpwr_pkg::seqStrobe_t   strobe,
  output logic                     reqPower,
  output logic                     guardDone
);

  localparam logic [GUARD_W-1:0] CNT_MAX  = {GUARD_W{1'b1}};
  localparam logic [DATA_W-1:0]  USED_MSK =
    (DATA_W'({GUARD_W{1'b1}}) << GUARD_LSB) | DATA_W'(1);

  logic               pwrReqQ;
  logic [GUARD_W-1:0] guardQ;
  logic [GUARD_W-1:0] guardEff;
  logic [GUARD_W-1:0] frameCnt;
  logic [GUARD_W:0]   cntNext;
  logic               unusedBits;

  assign unusedBits = ^(wrData & ~USED_MSK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrReqQ <= 1'b0;
      guardQ  <= GUARD_W'(GUARD_RST);
    end else if (wrEn) begin
      pwrReqQ <= wrData[0];
      guardQ  <= wrData[GUARD_LSB +: GUARD_W];
    end
  end

  // the write being sampled now takes effect at this same edge
  assign reqPower = wrEn ? wrData[0] : pwrReqQ;

  assign guardEff = (guardQ == '0) ? GUARD_W'(1) : guardQ;
  assign cntNext  = {1'b0, frameCnt} + 1'b1;
  assign guardDone = frameStart && (cntNext >= {1'b0, guardEff});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (strobe.cntClr) begin
      frameCnt <= '0;
    end else if (strobe.cntInc && frameCnt != CNT_MAX) begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcdpwr_ctrl.sv
module lcdpwr_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqPower,
  input  logic                    guardDone,
  input  logic                    frameStart,
  output lcdpwr_pkg::seqStrobe_t  strobe,
  output logic                    sigEn,
  output logic                    panelPwr,
  output logic                    busy
);
  import lcdpwr_pkg::*;

  pwrState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      PS_OFF:       if (reqPower) stateNext = PS_UP_WAIT;
      PS_UP_WAIT: begin
        if (!reqPower)      stateNext = PS_DOWN_WAIT;
        else if (guardDone) stateNext = PS_ON;
      end
      PS_ON:        if (!reqPower) stateNext = PS_DOWN_WAIT;
      PS_DOWN_WAIT: if (guardDone) stateNext = PS_DRAIN;
      PS_DRAIN:     stateNext = PS_OFF;
      default:      stateNext = PS_OFF;
    endcase
  end

  always_comb begin
    strobe.cntClr = (stateNext != stateQ);
    strobe.cntInc = frameStart && !strobe.cntClr &&
                    (stateQ == PS_UP_WAIT || stateQ == PS_DOWN_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= PS_OFF;
      sigEn    <= 1'b0;
      panelPwr <= 1'b0;
      busy     <= 1'b0;
    end else begin
      stateQ   <= stateNext;
      sigEn    <= (stateNext == PS_UP_WAIT) || (stateNext == PS_ON) ||
                  (stateNext == PS_DOWN_WAIT);
      panelPwr <= (stateNext == PS_ON);
      busy     <= (stateNext == PS_UP_WAIT) || (stateNext == PS_DOWN_WAIT) ||
                  (stateNext == PS_DRAIN);
    end
  end

endmodule

// File: rtl/lcdpwr_seq.sv
module lcdpwr_seq #(
  parameter int DATA_W    = 32,
  parameter int GUARD_W   = 8,
  parameter int GUARD_LSB = 16,
  parameter int GUARD_RST = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameStart,
  output logic              sigEn,
  output logic              panelPwr,
  output logic              busy
);

  lcdpwr_pkg::seqStrobe_t strobe;
  logic reqPower;
  logic guardDone;

  lcdpwr_cfg_dp #(
    .DATA_W(DATA_W), .GUARD_W(GUARD_W),
    .GUARD_LSB(GUARD_LSB), .GUARD_RST(GUARD_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .frameStart(frameStart), .strobe(strobe),
    .reqPower(reqPower), .guardDone(guardDone)
  );

  lcdpwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqPower(reqPower), .guardDone(guardDone),
    .frameStart(frameStart), .strobe(strobe),
    .sigEn(sigEn), .panelPwr(panelPwr), .busy(busy)
  );

endmodule

// File: rtl/lcdpwr_seq_chk.sv
module lcdpwr_seq_chk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic sigEn,
  input logic panelPwr,
  input logic busy
);

  // R3/R4: panel power never on without the signal group
  a_r3_pwr_needs_sig: assert property (@(posedge clk) disable iff (!rstN)
    panelPwr |-> sigEn);

  a_r3_pwr_rise_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(panelPwr) |-> ($past(frameStart) && $past(sigEn)));

  a_r4_sig_fall_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sigEn) |-> ($past(frameStart) && !$past(panelPwr)));

  a_r5_busy_holds_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sigEn) |-> busy);

  a_r5_busy_clears_after: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sigEn) |=> !busy);

  a_r9_busy_in_transition: assert property (@(posedge clk) disable iff (!rstN)
    (sigEn && !panelPwr) |-> busy);

endmodule

bind lcdpwr_seq lcdpwr_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart),
  .sigEn(sigEn), .panelPwr(panelPwr), .busy(busy)
);

// File: tb/lcdpwr_seq_bench.sv
module lcdpwr_seq_bench;

  localparam int DW = 8;
  localparam int GW = 3;
  localparam int GL = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic frameStart = 1'b0;
  logic sigEn, panelPwr, busy;

  int nChecks = 0;
  int nErrors = 0;
  bit doneFlag = 1'b0;

  typedef struct {
    logic [2:0] exp;  // {sigEn, panelPwr, busy}
    string      tag;
  } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;

  lcdpwr_seq #(.DATA_W(DW), .GUARD_W(GW), .GUARD_LSB(GL)) u_lcdpwr_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .frameStart(frameStart), .sigEn(sigEn), .panelPwr(panelPwr), .busy(busy)
  );

  // monitor: outputs are stable between the negedge push and this edge
  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nChecks++;
      if ({sigEn, panelPwr, busy} !== it.exp) begin
        nErrors++;
        $display("FAIL %s: got sig/pwr/busy=%b expected %b", it.tag,
                 {sigEn, panelPwr, busy}, it.exp);
      end
    end
  end

  task automatic expect3(string tag, logic [2:0] e);
    item_t it;
    it.exp = e;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doWrite(logic pwr, logic [GW-1:0] g, logic [3:0] junk);
    wrEn = 1'b1;
    wrData = {junk, g, pwr};
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic doFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expect3("R1 reset", 3'b000);
    idle();
    // R7: frames while off
    doFrame(); expect3("R7 frame while off", 3'b000);
    doFrame(); expect3("R7 frame while off", 3'b000);
    // R2/R3: power up guard 2, junk in unused bits
    doWrite(1'b1, 3'd2, 4'hF); expect3("R2 R3 sig first", 3'b101);
    idle();    expect3("R3 waiting", 3'b101);
    doFrame(); expect3("R3 one frame", 3'b101);
    idle();    expect3("R3 waiting", 3'b101);
    doFrame(); expect3("R3 power on", 3'b110);
    // R10 / R7
    doWrite(1'b1, 3'd5, 4'h0); expect3("R10 rewrite while on", 3'b110);
    doFrame(); expect3("R7 frame while on", 3'b110);
    // R4/R5: power down guard 3
    doWrite(1'b0, 3'd3, 4'hA); expect3("R4 pwr drops first", 3'b101);
    doFrame(); expect3("R4 sig held", 3'b101);
    doFrame(); expect3("R4 sig held", 3'b101);
    doFrame(); expect3("R4 R5 sig off busy", 3'b001);
    idle();    expect3("R5 idle", 3'b000);
    // R6: guard 0 behaves as 1
    doWrite(1'b1, 3'd0, 4'h0); expect3("R6 up", 3'b101);
    doFrame(); expect3("R6 on after one frame", 3'b110);
    doWrite(1'b0, 3'd0, 4'h0); expect3("R6 down", 3'b101);
    doFrame(); expect3("R6 sig off after one frame", 3'b001);
    idle();    expect3("R6 idle", 3'b000);
    // R8: abort power-up
    doWrite(1'b1, 3'd4, 4'h0); expect3("R8 up", 3'b101);
    doFrame(); expect3("R8 waiting", 3'b101);
    doWrite(1'b0, 3'd1, 4'h0); expect3("R8 abort no pwr", 3'b101);
    doFrame(); expect3("R8 sig off", 3'b001);
    idle();    expect3("R8 idle", 3'b000);
    // R3 boundary: maximum guard 7
    doWrite(1'b1, 3'd7, 4'h5); expect3("R3 max up", 3'b101);
    for (int i = 0; i < 6; i++) begin
      doFrame(); expect3("R3 max waiting", 3'b101);
    end
    doFrame(); expect3("R3 max power on", 3'b110);
    // R9: re-request during shutdown
    doWrite(1'b0, 3'd1, 4'h0); expect3("R9 down", 3'b101);
    doWrite(1'b1, 3'd1, 4'h0); expect3("R9 shutdown continues", 3'b101);
    doFrame(); expect3("R9 sig off", 3'b001);
    idle();    expect3("R9 idle cycle", 3'b000);
    idle();    expect3("R9 restart", 3'b101);
    doFrame(); expect3("R9 power on again", 3'b110);
    repeat (3) @(negedge clk);
    doneFlag = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !doneFlag; c++) @(negedge clk);
    if (!doneFlag) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule